// File: doc/BRIEF.md
# Glitch-Free Serial Clock Generator for Smart Card Links

This block produces the serial clock driven to a smart card contact. It divides the system clock by a programmable half-period count. Each high phase and each low phase of the output lasts exactly that many system clock cycles. A run bit starts the clock and asks it to stop. A level bit selects the static level the pin holds while the clock is parked.

Start and stop requests take effect only on phase boundaries. The output parks only on the edge that brings it to the selected idle level. When the clock restarts, the idle level is held for a full fresh half-period before the first edge. As a result the pin never carries a shortened high or low phase. The transmit and receive enables are inputs so that firmware can clear them in the same write that updates the level bit. They do not disturb the clock.

The output-enable is low during reset, so the pin floats on its external pull resistor. It turns on at the first clock after reset. By then the output register already holds the selected idle level.

Top module: `sc_clk_gen`

## Requirements
- R1: While `rst_ni` is low, `sck_oe_o` is 0, `stopped_o` is 1 and `sck_o` is 0.
- R2: On the first clock edge after reset release, `sck_oe_o` becomes 1 and `sck_o` takes the value of `idle_lvl_i`. After that, `sck_oe_o` stays 1.
- R3: While parked, `sck_o` follows `idle_lvl_i` with a delay of one clock.
- R4: While running, every high and low phase of `sck_o` lasts exactly `div_i` clock cycles. This includes the last phase before parking. A `div_i` value of 0 is treated as 1.
- R5: When `run_i` is sampled at 1 while parked, `sck_o` holds the idle level for `div_i` more cycles. Then it toggles, and `stopped_o` falls on that same edge. Measured from a mid-cycle change of `run_i`, the fall comes `div_i`+1 sampling points later.
- R6: Once `run_i` is 0, the clock parks on the next edge that brings `sck_o` to `idle_lvl_i`, and `stopped_o` rises on that edge. This happens within 2×`div_i`+1 cycles of the request.
- R7: `tx_en_i` and `rx_en_i` have no effect on `sck_o` or `stopped_o`.
- R8: While running, `run_i` is sampled only at phase boundaries. A low pulse on `run_i` that ends before the next boundary does not stop the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Half-period length in clock cycles |
| run_i | input | 1 | 1 starts the clock, 0 requests a stop |
| idle_lvl_i | input | 1 | Level held on the pin while parked |
| tx_en_i | input | 1 | Transmit enable, no effect on the clock |
| rx_en_i | input | 1 | Receive enable, no effect on the clock |
| sck_o | output | 1 | Serial clock pin value |
| sck_oe_o | output | 1 | Pin output-enable |
| stopped_o | output | 1 | High while the clock is parked |

## Verification
A phase counter that is off by one shows at `sck_o` as a phase of the wrong length, so it is caught at the very next toggle. A run/park state that goes wrong shows up within one serial period. Either `stopped_o` changes in the wrong cycle, or `sck_o` parks at the non-idle level and so leaves a short phase. The bench runs a cycle-accurate model next to the design and compares `sck_o`, `sck_oe_o` and `stopped_o` on every clock. Any such fault is therefore reported in the cycle where it first shows at the pins.

// File: rtl/sc_clk_pkg.sv
`timescale 1ns/1ps
package sc_clk_pkg;
  typedef enum logic {
    ST_PARKED = 1'b0,
    ST_RUN    = 1'b1
  } sc_clk_st_e;
endpackage

// File: rtl/sc_clk_cnt.sv
`timescale 1ns/1ps
module sc_clk_cnt #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] term;

  // zero divisor behaves as one
  assign term   = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = en_i && (cnt_q >= term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else if (en_i)             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0)); // R4
  AST_CLR_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/sc_clk_ctl.sv
`timescale 1ns/1ps
module sc_clk_ctl
  import sc_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic idle_lvl_i,
  output logic cnt_clr_o,
  output logic cnt_en_o,
  output logic sck_o,
  output logic stopped_o
);
  sc_clk_st_e st_q;
  logic       sck_q;
  logic       stopped_q;

  assign cnt_clr_o = (st_q == ST_PARKED);
  assign cnt_en_o  = (st_q == ST_RUN);
  assign sck_o     = sck_q;
  assign stopped_o = stopped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_PARKED;
      sck_q     <= 1'b0;
      stopped_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_PARKED: begin
          sck_q <= idle_lvl_i;
          if (run_i) st_q <= ST_RUN;
        end
        ST_RUN: begin
          if (tick_i) begin
            sck_q <= ~sck_q;
            // park only on the edge that lands on the idle level
            if (!run_i && (sck_q != idle_lvl_i)) begin
              st_q      <= ST_PARKED;
              stopped_q <= 1'b1;
            end else begin
              stopped_q <= 1'b0;
            end
          end
        end
        default: st_q <= ST_PARKED;
      endcase
    end
  end

  AST_PARK_FOLLOWS_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PARKED) |=> (sck_q == $past(idle_lvl_i))); // R3
  AST_EDGE_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !tick_i) |=> $stable(sck_q)); // R4
  AST_START_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stopped_q) |-> (sck_q != $past(sck_q))); // R5
  AST_PARK_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_q) |-> (sck_q == $past(idle_lvl_i))); // R6
  AST_RUN_HOLD_MIDPHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !tick_i) |=> (st_q == ST_RUN)); // R8
endmodule

// File: rtl/sc_clk_gen.sv
`timescale 1ns/1ps
module sc_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  input  logic             idle_lvl_i,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  output logic             sck_o,
  output logic             sck_oe_o,
  output logic             stopped_o
);
  logic tick;
  logic cnt_clr;
  logic cnt_en;
  logic oe_q;

  sc_clk_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .div_i  (div_i),
    .tick_o (tick)
  );

  sc_clk_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .run_i      (run_i),
    .idle_lvl_i (idle_lvl_i),
    .cnt_clr_o  (cnt_clr),
    .cnt_en_o   (cnt_en),
    .sck_o      (sck_o),
    .stopped_o  (stopped_o)
  );

  // pin floats in reset; driven once the idle level is loaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= 1'b1;
  end
  assign sck_oe_o = oe_q;

  AST_OE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_oe_o |=> sck_oe_o); // R2
  AST_OE_WITH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_oe_o) |-> (sck_o == $past(idle_lvl_i))); // R2
  AST_TXRX_NO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stopped_o && run_i && ($fell(tx_en_i) || $fell(rx_en_i))) |=> !stopped_o); // R7
endmodule

// File: tb/sc_clk_gen_tb.sv
`timescale 1ns/1ps
module sc_clk_gen_tb;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, idle = 1'b0, txe = 1'b0, rxe = 1'b0;
  logic [DIV_W-1:0] div = 8'd3;
  logic sck, oe, stp;

  int    n_vec = 0;
  int    n_bad = 0;
  string req = "R1";

  // behavioural reference
  bit m_sck = 1'b0, m_oe = 1'b0, m_stop = 1'b1, m_run = 1'b0;
  int age = 0;

  always #4 clk = ~clk;

  sc_clk_gen #(.DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .run_i(run),
    .idle_lvl_i(idle), .tx_en_i(txe), .rx_en_i(rxe),
    .sck_o(sck), .sck_oe_o(oe), .stopped_o(stp)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sck = 1'b0; m_oe = 1'b0; m_stop = 1'b1; m_run = 1'b0; age = 0;
    end else begin
      int d;
      d = (div == 0) ? 1 : int'(div);
      m_oe = 1'b1;
      if (!m_run) begin
        m_sck = idle;
        age = 0;
        if (run) m_run = 1'b1;
      end else begin
        age++;
        if (age >= d) begin
          age = 0;
          m_sck = ~m_sck;
          if (!run && (m_sck == idle)) begin
            m_run = 1'b0; m_stop = 1'b1;
          end else begin
            m_stop = 1'b0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    n_vec++;
    if (sck !== m_sck || oe !== m_oe || stp !== m_stop) begin
      n_bad++;
      $display("FAIL %s t=%0t sck=%b/%b oe=%b/%b stopped=%b/%b (act/exp)",
               req, $time, sck, m_sck, oe, m_oe, stp, m_stop);
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic meas(output int w);
    logic p;
    @(negedge clk);
    p = sck;
    while (sck == p) @(negedge clk);
    p = sck;
    w = 0;
    while (sck == p) begin
      @(negedge clk);
      w++;
    end
    #1;
  endtask

  task automatic wait_stop(output int k);
    k = 0;
    while (stp !== 1'b1 && k < 1000) begin
      @(negedge clk);
      k++;
    end
    #1;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int w, k;
    req = "R1";
    cyc(3);
    chk("R1 oe", int'(oe), 0);
    chk("R1 stopped", int'(stp), 1);
    chk("R1 sck", int'(sck), 0);

    rst_n = 1'b1;
    req = "R2";
    cyc(2);
    chk("R2 oe", int'(oe), 1);
    chk("R2 sck idle", int'(sck), 0);

    req = "R3";
    idle = 1'b1; cyc(2);
    chk("R3 sck", int'(sck), 1);
    idle = 1'b0; cyc(2);
    chk("R3 sck", int'(sck), 0);
    idle = 1'b1; cyc(2);

    req = "R5";
    div = 8'd3;
    run = 1'b1;
    k = 0;
    while (stp === 1'b1 && k < 1000) begin
      @(negedge clk);
      k++;
    end
    #1;
    chk("R5 start delay", k, 4);

    req = "R4";
    meas(w); chk("R4 div3", w, 3);
    meas(w); chk("R4 div3", w, 3);
    div = 8'd1; cyc(4);
    meas(w); chk("R4 div1", w, 1);
    div = 8'd0; cyc(4);
    meas(w); chk("R4 div0", w, 1);
    div = 8'd5; cyc(12);
    meas(w); chk("R4 div5", w, 5);

    req = "R6";
    for (int off = 0; off < 6; off++) begin
      idle = off[0];
      run = 1'b1;
      cyc(7 + off);
      run = 1'b0;
      wait_stop(k);
      chk("R6 park latency ok", int'(k <= 11), 1);
      cyc(1);
      chk("R6 parked level", int'(sck), int'(idle));
    end

    req = "R7";
    div = 8'd4;
    run = 1'b1; txe = 1'b1; rxe = 1'b1;
    cyc(12);
    txe = 1'b0; rxe = 1'b0;
    cyc(20);
    chk("R7 still running", int'(stp), 0);
    meas(w); chk("R7 width", w, 4);

    req = "R8";
    div = 8'd6;
    meas(w);
    cyc(2);
    run = 1'b0; cyc(1);
    run = 1'b1; cyc(20);
    chk("R8 not stopped", int'(stp), 0);
    meas(w); chk("R8 width", w, 6);

    run = 1'b0;
    cyc(30);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule